// File: doc/BRIEF.md
# Flagged audio error concealment unit

This block sits after the last error-correction stage of a digital audio path. It receives one stereo frame per transfer. Each channel's sample comes with a flag that marks the sample as unreliable. The block hides those damaged samples before they reach the rest of the audio chain. A short burst of flagged samples is bridged with the midpoint between the good samples on either side of it. A long burst is replaced by silence, because bridging a long gap would produce an audible artefact.

A short run and a long run can only be told apart once enough later samples are known. For that reason every frame waits in a four-entry window before it leaves the block. When a flagged sample reaches the head of the window, the three frames behind it show whether the run is at least four long. If the run is shorter, those frames also hold the good sample that ends it. Each channel keeps its own last-good value and its own mute state. Both ends of the block use valid/ready handshakes. A stalled output holds the whole window in place.

Top module: `flag_conceal`

## Requirements
- R1: A sample whose flag is 0 leaves the block bit-exact, in its original position in the stream. Flag bit c of `in_flag` belongs to channel c. Channel c occupies bits `c*16 +: 16` of `in_data` and `out_data`, and channel 0 is left.
- R2: In a run of one to three consecutive flagged samples, each sample is replaced by floor((P + N) / 2). P is the last unflagged sample before the run and N is the first unflagged sample after it. Both are taken as signed 16-bit values, and the sum is formed one bit wider so it never overflows.
- R3: When a run of flagged samples is four or longer, every sample in that run, including those beyond the fourth, is output as exactly 0. The first unflagged sample after the run passes through unchanged.
- R4: If a short run occurs before any unflagged sample has left the block since reset, P is taken as 0.
- R5: Each channel tracks its runs, its P value and its mute state independently. A run on one channel does not alter the output of the other.
- R6: `out_valid` is 1 exactly when four accepted frames are held and not yet emitted. It stays 0 after reset until the fourth frame has been accepted.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged on the next cycle. No frame is lost or reordered.
- R8: `in_ready` is 1 exactly when the window is not full or the head frame is being taken in the same cycle.
- R9: A synchronous active-low reset empties the window, clears each channel's P to 0 and ends any muting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input frame present |
| in_ready | output | 1 | Block can take the input frame |
| in_data | input | 32 | Signed samples, channel c at bits c*16 +: 16 |
| in_flag | input | 2 | Per-channel unreliable flag, bit c for channel c |
| out_valid | output | 1 | Output frame present |
| out_ready | input | 1 | Downstream takes the output frame |
| out_data | output | 32 | Concealed samples, same layout as in_data |

## Verification
The bench uses the default parameters: 16-bit samples, two channels and a four-entry window. With these values the full-scale extremes reach the midpoint adder, where a sum that is not widened would wrap. Runs of exactly three and exactly four flagged samples fall on either side of the mute threshold. Runs of five and six check that muting stays on past the window depth. The second channel gets runs placed differently from the first, so any coupling between the two lanes shows up. A reset in the middle of a stream, followed by a replay that starts with flagged samples, shows whether the last-good values really return to zero.

// File: rtl/conceal_pkg.sv
// Shared definitions for the flagged-sample concealment block.
// Assumes nothing beyond standard SystemVerilog.
package conceal_pkg;

    // What a lane does with the sample currently at the head of the window.
    typedef enum logic [1:0] {
        ACT_PASS   = 2'd0,
        ACT_INTERP = 2'd1,
        ACT_MUTE   = 2'd2
    } conceal_act_e;

endpackage

// File: rtl/conceal_window.sv
// Look-ahead window: an in-order shift queue of WIN stereo frames with flags.
// Entry 0 is the oldest frame. A pop shifts every entry one place toward the
// head. A push writes behind the youngest valid entry.
// Assumes the caller never pushes into a full window unless it pops in the
// same cycle, and never pops an empty one.
module conceal_window #(
    parameter int FRAME_W = 32,
    parameter int NUM_CH  = 2,
    parameter int WIN     = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              push,
    input  logic                              pop,
    input  logic [FRAME_W-1:0]                push_data,
    input  logic [NUM_CH-1:0]                 push_flag,
    output logic [WIN-1:0][FRAME_W-1:0]       slot_data,
    output logic [WIN-1:0][NUM_CH-1:0]        slot_flag,
    output logic                              full
);

    localparam int CNT_W = $clog2(WIN + 1);

    logic [WIN-1:0][FRAME_W-1:0] data_q, data_d;
    logic [WIN-1:0][NUM_CH-1:0]  flag_q, flag_d;
    logic [CNT_W-1:0]            cnt_q, cnt_d, base;

    // Next window contents: shift on pop, then append on push.
    always_comb begin
        data_d = data_q;
        flag_d = flag_q;
        base   = cnt_q;
        if (pop) begin
            for (int i = 0; i < WIN - 1; i++) begin
                data_d[i] = data_q[i+1];
                flag_d[i] = flag_q[i+1];
            end
            data_d[WIN-1] = '0;
            flag_d[WIN-1] = '0;
            base          = cnt_q - 1'b1;
        end
        if (push) begin
            for (int i = 0; i < WIN; i++) begin
                if (CNT_W'(i) == base) begin
                    data_d[i] = push_data;
                    flag_d[i] = push_flag;
                end
            end
        end
        cnt_d = base + CNT_W'(push);
    end

    // Window registers, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            flag_q <= '0;
            cnt_q  <= '0;
        end else begin
            data_q <= data_d;
            flag_q <= flag_d;
            cnt_q  <= cnt_d;
        end
    end

    assign slot_data = data_q;
    assign slot_flag = flag_q;
    assign full      = (cnt_q == CNT_W'(WIN));

endmodule

// File: rtl/conceal_lane.sv
// One channel's concealment decision. It looks at that channel's WIN window
// slots and picks pass, midpoint interpolation or mute for the head sample.
// It keeps the last good sample emitted and a sticky mute state, and both
// change only when the head sample leaves (pop).
// Assumes the window is full whenever the output is used, so a short run
// always has its closing good sample inside slots 1..WIN-1.
module conceal_lane
    import conceal_pkg::*;
#(
    parameter int W   = 16,
    parameter int WIN = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pop,
    input  logic [WIN-1:0][W-1:0] slot_data,
    input  logic [WIN-1:0]        slot_flag,
    output logic [W-1:0]          sample_out
);

    logic [W-1:0]  prev_good_q;
    logic          muting_q;
    logic [W-1:0]  next_good;
    logic          next_found;
    logic          run_long;
    logic [W:0]    pair_sum;
    logic [W-1:0]  midpoint;
    conceal_act_e  act;

    // Find the first unflagged sample behind the head (the nearest slot wins).
    always_comb begin
        next_good  = '0;
        next_found = 1'b0;
        for (int i = WIN - 1; i >= 1; i--) begin
            if (!slot_flag[i]) begin
                next_good  = slot_data[i];
                next_found = 1'b1;
            end
        end
    end

    // A run that fills the whole window is at least WIN long.
    assign run_long = &slot_flag;

    // Midpoint in W+1 bits, then an arithmetic halving that rounds down.
    assign pair_sum = {prev_good_q[W-1], prev_good_q} + {next_good[W-1], next_good};
    assign midpoint = pair_sum[W:1];

    // Choose the action for the head sample.
    always_comb begin
        if (!slot_flag[0])
            act = ACT_PASS;
        else if (muting_q || run_long || !next_found)
            act = ACT_MUTE;
        else
            act = ACT_INTERP;
    end

    // Drive the concealed head sample.
    always_comb begin
        unique case (act)
            ACT_PASS:   sample_out = slot_data[0];
            ACT_INTERP: sample_out = midpoint;
            default:    sample_out = '0;
        endcase
    end

    // Track the last good sample and the mute state as samples leave.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_good_q <= '0;
            muting_q    <= 1'b0;
        end else if (pop) begin
            case (act)
                ACT_PASS: begin
                    prev_good_q <= slot_data[0];
                    muting_q    <= 1'b0;
                end
                ACT_MUTE:   muting_q <= 1'b1;
                default:    muting_q <= muting_q;
            endcase
        end
    end

endmodule

// File: rtl/flag_conceal.sv
// Top of the concealment block. It accepts stereo frames with per-channel
// unreliable flags, holds them in a WIN-deep look-ahead window and emits each
// frame with flagged samples interpolated or muted. Both ends use valid/ready.
// The output is valid only while the window is full, and a stall freezes it.
// Assumes SAMPLE_W-bit two's complement samples packed channel 0 lowest.
module flag_conceal #(
    parameter int SAMPLE_W = 16,
    parameter int NUM_CH   = 2,
    parameter int WIN      = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [NUM_CH*SAMPLE_W-1:0]   in_data,
    input  logic [NUM_CH-1:0]            in_flag,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [NUM_CH*SAMPLE_W-1:0]   out_data
);

    localparam int FRAME_W = NUM_CH * SAMPLE_W;

    logic                                      full;
    logic                                      push;
    logic                                      pop;
    logic [WIN-1:0][FRAME_W-1:0]               win_data;
    logic [WIN-1:0][NUM_CH-1:0]                win_flag;
    logic [NUM_CH-1:0][WIN-1:0][SAMPLE_W-1:0]  lane_data;
    logic [NUM_CH-1:0][WIN-1:0]                lane_flag;
    logic [NUM_CH-1:0][SAMPLE_W-1:0]           lane_out;

    // Handshake: emit only from a full window; accept while room or draining.
    assign out_valid = full;
    assign pop       = full && out_ready;
    assign in_ready  = !full || out_ready;
    assign push      = in_valid && in_ready;

    conceal_window #(
        .FRAME_W (FRAME_W),
        .NUM_CH  (NUM_CH),
        .WIN     (WIN)
    ) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .push_data (in_data),
        .push_flag (in_flag),
        .slot_data (win_data),
        .slot_flag (win_flag),
        .full      (full)
    );

    // Slice the window per channel and give each channel its own lane.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        for (genvar i = 0; i < WIN; i++) begin : g_slot
            assign lane_data[c][i] = win_data[i][c*SAMPLE_W +: SAMPLE_W];
            assign lane_flag[c][i] = win_flag[i][c];
        end

        conceal_lane #(
            .W   (SAMPLE_W),
            .WIN (WIN)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .pop        (pop),
            .slot_data  (lane_data[c]),
            .slot_flag  (lane_flag[c]),
            .sample_out (lane_out[c])
        );

        assign out_data[c*SAMPLE_W +: SAMPLE_W] = lane_out[c];
    end

endmodule

// File: rtl/flag_conceal_chk.sv
// Port-level checker for flag_conceal, attached to every instance by bind.
// It keeps its own count of frames held, based on the handshakes.
module flag_conceal_chk #(
    parameter int SAMPLE_W = 16,
    parameter int NUM_CH   = 2,
    parameter int WIN      = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic                       in_ready,
    input logic                       out_valid,
    input logic                       out_ready,
    input logic [NUM_CH*SAMPLE_W-1:0] out_data
);

    localparam int OCC_W = $clog2(WIN + 1) + 1;

    logic [OCC_W-1:0] occ;

    // Independent occupancy count derived from accepted and emitted frames.
    always_ff @(posedge clk) begin
        if (!rst_n)
            occ <= '0;
        else
            occ <= occ + OCC_W'(in_valid && in_ready) - OCC_W'(out_valid && out_ready);
    end

    // R9: reset leaves no frame to emit.
    assert_reset_empty_R9: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R6: output valid exactly when the checker counts a full window.
    assert_fill_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == (occ == OCC_W'(WIN)));

    // R7: a stalled output frame stays valid and unchanged.
    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R8: room, or a drain in the same cycle, means the input is accepted.
    assert_ready_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (occ < OCC_W'(WIN) || out_ready) |-> in_ready);

    // R8: a full, stalled window refuses input.
    assert_ready_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

endmodule

bind flag_conceal flag_conceal_chk #(
    .SAMPLE_W (SAMPLE_W),
    .NUM_CH   (NUM_CH),
    .WIN      (WIN)
) u_flag_conceal_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/test_flag_conceal.sv
// Bench for flag_conceal: directed corner runs followed by random bursty
// flags. Each output frame is compared with a model built from the
// requirements.
module test_flag_conceal;

    localparam int N   = 800;
    localparam int WIN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic [1:0]  in_flag = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;

    logic [15:0] sd [0:1][0:N-1];
    bit          fl [0:1][0:N-1];

    int n_cmp = 0;
    int n_bad = 0;
    int iidx, oidx;
    bit hung = 1'b0;

    always #10 clk = ~clk;

    flag_conceal #(.SAMPLE_W(16), .NUM_CH(2), .WIN(WIN)) i_flag_conceal (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_flag   (in_flag),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input int ch, input int k, input int v, input bit f);
        sd[ch][k] = 16'(v);
        fl[ch][k] = f;
    endtask

    // Expected output for sample k of channel ch, derived from R1-style rules.
    function automatic logic [15:0] expect_at(input int ch, input int k, output string tag);
        int s;
        int l;
        logic [15:0] pv;
        logic [15:0] nx;
        logic [16:0] sm;
        if (!fl[ch][k]) begin
            tag = "R1 pass";
            return sd[ch][k];
        end
        s = k;
        while (s > 0 && fl[ch][s-1]) s--;
        l = 0;
        while (l < 4 && s + l < N && fl[ch][s+l]) l++;
        if (l >= 4 || s + l >= N) begin
            tag = "R3 mute";
            return 16'h0000;
        end
        pv  = (s > 0) ? sd[ch][s-1] : 16'h0000;
        tag = (s > 0) ? "R2 interp" : "R4 interp from zero";
        nx  = sd[ch][s+l];
        sm  = {pv[15], pv} + {nx[15], nx};
        return sm[16:1];
    endfunction

    // Drive a stream of `limit` frames and check every cycle until all emit.
    task automatic run_stream(input int limit);
        bit          stalled = 1'b0;
        logic [31:0] held = '0;
        int          guard = 0;
        iidx = 0;
        oidx = 0;
        while (oidx < limit - (WIN - 1)) begin
            @(negedge clk);
            in_valid = (iidx < limit) && ($urandom_range(0, 3) != 0);
            if (iidx < limit) begin
                in_data = {sd[1][iidx], sd[0][iidx]};
                in_flag = {fl[1][iidx], fl[0][iidx]};
            end
            out_ready = ($urandom_range(0, 3) != 0);
            #1;
            check(out_valid == ((iidx - oidx) == WIN), "R6 fill level", 32'(out_valid), 32'((iidx - oidx) == WIN));
            check(in_ready == (((iidx - oidx) < WIN) || out_ready), "R8 ready", 32'(in_ready),
                  32'(((iidx - oidx) < WIN) || out_ready));
            if (stalled)
                check(out_valid && out_data == held, "R7 stall hold", out_data, held);
            if (out_valid && out_ready) begin
                for (int ch = 0; ch < 2; ch++) begin
                    string       tag;
                    logic [15:0] e;
                    e = expect_at(ch, oidx, tag);
                    if (ch == 1) tag = {tag, " R5 ch1"};
                    check(out_data[ch*16 +: 16] == e, tag, 32'(out_data[ch*16 +: 16]), 32'(e));
                end
                oidx++;
            end
            stalled = out_valid && !out_ready;
            held    = out_data;
            if (in_valid && in_ready) iidx++;
            guard++;
            if (guard > 20 * limit + 100) begin
                hung = 1'b1;
                check(1'b0, "watchdog expired", 32'(oidx), 32'(limit - (WIN - 1)));
                break;
            end
        end
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b0;
    endtask

    initial begin
        int run_left;
        void'($urandom(32'd2024));

        // Default: good random samples everywhere.
        for (int ch = 0; ch < 2; ch++)
            for (int k = 0; k < N; k++)
                put(ch, k, int'($urandom_range(0, 65535)), 1'b0);

        // Channel 0 directed runs.
        put(0, 0, 123, 1); put(0, 1, -5, 1); put(0, 2, 1000, 0);
        put(0, 3, -7, 0); put(0, 4, 0, 1); put(0, 5, 9, 0);
        put(0, 6, 32767, 0); put(0, 7, 0, 1); put(0, 8, 32767, 0);
        put(0, 9, -32768, 0); put(0, 10, 5, 1); put(0, 11, 6, 1); put(0, 12, -32768, 0);
        put(0, 13, 32767, 0); put(0, 14, 1, 1); put(0, 15, 2, 1); put(0, 16, 3, 1);
        put(0, 17, -32768, 0);
        put(0, 18, -3, 0); put(0, 19, 8, 1); put(0, 20, 0, 0);
        put(0, 21, 5, 0);
        for (int k = 22; k < 26; k++) put(0, k, 1111, 1);
        put(0, 26, 77, 0);
        for (int k = 27; k < 33; k++) put(0, k, -2222, 1);
        put(0, 33, 100, 0);

        // Channel 1 directed runs, placed apart from channel 0's.
        put(1, 0, 200, 0);
        for (int k = 1; k < 5; k++) put(1, k, 4444, 1);
        put(1, 5, 300, 0);
        put(1, 9, 100, 0); put(1, 10, 7, 1); put(1, 11, 400, 0);
        put(1, 19, -50, 0); put(1, 20, 1, 1); put(1, 21, 2, 1); put(1, 22, 3, 1); put(1, 23, 50, 0);

        // Random bursty flags after the directed region.
        for (int ch = 0; ch < 2; ch++) begin
            run_left = 0;
            for (int k = 40; k < N; k++) begin
                if (run_left == 0 && $urandom_range(0, 9) == 0)
                    run_left = int'($urandom_range(1, 6));
                fl[ch][k] = (run_left > 0);
                if (run_left > 0) run_left--;
            end
        end

        // Reset state.
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R9 reset out_valid", 32'(out_valid), 32'd0);
        out_ready = 1'b0;
        #1;
        check(in_ready == 1'b1, "R9 reset in_ready", 32'(in_ready), 32'd1);
        @(negedge clk);
        rst_n = 1'b1;

        run_stream(N);

        // Reset with three frames still held, then replay the start.
        if (!hung) begin
            @(negedge clk);
            rst_n = 1'b0;
            repeat (2) @(negedge clk);
            #1;
            check(out_valid == 1'b0, "R9 mid-stream reset empties window", 32'(out_valid), 32'd0);
            @(negedge clk);
            rst_n = 1'b1;
            run_stream(40);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule